// File: doc/BRIEF.md
# Packet Receive Threshold Full Detector

This block watches the bytes a host pushes into a small packet buffer and tells the controller when the expected amount has arrived. Each time the data-request line goes from low to high, the block opens a new transfer. At that edge it samples a command-or-data select bit and a programmed byte count, and from them it sets the number of bytes that counts as a complete packet. If the select bit is high, a command packet is expected and that number is 12. If the select bit is low, the number is the programmed count, which is below 12 in normal use.

A byte counter advances once for every host write strobe. When the counter reaches the chosen number, a sticky full-packet flag is raised. The counter can be zeroed at any time by a buffer clear. The flag stays set until the next data-request rising edge or a reset. Host writes have no back-pressure: the strobe is a plain pulse that the block always takes, and the counter saturates at 12. Data-request, the select bit, the programmed count and the clear are plain control pins.

Top module: `pkt_thr_det`

## Requirements
- R1: After reset `byte_cnt` is 0 and `full_flag` is 0.
- R2: On a `drq` 0-to-1 edge with `cmd_sel` = 1, the threshold becomes 12. `full_flag` rises on the clock edge that takes the 12th byte and not before.
- R3: On a `drq` 0-to-1 edge with `cmd_sel` = 0, the threshold becomes `prog_cnt`, a 4-bit unsigned value. Values 12 to 15 are treated as 12.
- R4: Changes to `cmd_sel` or `prog_cnt` after the `drq` edge do not alter the latched threshold.
- R5: A `drq` 0-to-1 edge zeroes `byte_cnt` and clears `full_flag` on that clock edge. A `wr_stb` in the same cycle is not counted.
- R6: Each cycle with `wr_stb` high, and without a clear or a `drq` edge, adds 1 to `byte_cnt` at that clock edge. The count saturates at 12.
- R7: `fifo_clr` zeroes `byte_cnt` at the next edge and overrides a `wr_stb` in the same cycle. It leaves `full_flag` unchanged.
- R8: Once set, `full_flag` stays high through further writes, clears and `drq` falling, until the next `drq` rising edge or reset.
- R9: With a latched threshold of 0, `full_flag` stays low until the first counted byte, and goes high on that byte.
- R10: Only a 0-to-1 edge of `drq` re-latches the threshold. Holding `drq` high or letting it fall leaves the count and threshold alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| drq | input | 1 | Data-request level; its rising edge opens a transfer |
| cmd_sel | input | 1 | 1 = command packet (12 bytes), 0 = data of programmed length |
| prog_cnt | input | 4 | Programmed byte count for data transfers |
| wr_stb | input | 1 | One host byte written this cycle |
| fifo_clr | input | 1 | Zero the byte count |
| full_flag | output | 1 | Sticky full-packet flag |
| byte_cnt | output | 4 | Bytes counted in the current transfer |

## Verification
The two functions that can collide are opening a transfer and counting a byte. This happens when the host strobes a byte in the same cycle that `drq` first goes high. The bench provokes it by raising `drq` and `wr_stb` on the same falling edge, after a transfer has left the flag set. The correct result is a count of 0 with the flag cleared: the write is dropped and the old flag is gone. The same directed section also drives a clear together with a write, where the count must be 0 and the flag must keep its value.

// File: rtl/pkt_thr_pkg.sv
package pkt_thr_pkg;
  localparam int DEF_CMD_BYTES = 12;
  localparam int DEF_PROG_W    = 4;

  typedef enum logic [1:0] {
    CA_HOLD = 2'd0,
    CA_ZERO = 2'd1,
    CA_INC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/pkt_drq_edge.sv
module pkt_drq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic drq,
  output logic drq_rise
);
  logic drq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq_q <= 1'b0;
    else        drq_q <= drq;
  end

  assign drq_rise = drq & ~drq_q;
endmodule

// File: rtl/pkt_thr_latch.sv
module pkt_thr_latch #(
  parameter int CMD_BYTES = pkt_thr_pkg::DEF_CMD_BYTES,
  parameter int PROG_W    = pkt_thr_pkg::DEF_PROG_W,
  parameter int CNT_W     = $clog2(CMD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cmd_sel,
  input  logic [PROG_W-1:0] prog_cnt,
  output logic [CNT_W-1:0]  thr
);
  localparam int PROG_MAX = (1 << PROG_W) - 1;

  logic [CNT_W-1:0] data_thr;
  logic [CNT_W-1:0] thr_nxt;

  // Clamp only when the programmed field can express more than a command packet
  generate
    if (PROG_MAX > CMD_BYTES) begin : g_clamp
      always_comb begin
        if (prog_cnt > PROG_W'(CMD_BYTES)) data_thr = CNT_W'(CMD_BYTES);
        else                               data_thr = CNT_W'(prog_cnt);
      end
    end else begin : g_direct
      assign data_thr = CNT_W'(prog_cnt);
    end
  endgenerate

  assign thr_nxt = cmd_sel ? CNT_W'(CMD_BYTES) : data_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    thr <= CNT_W'(CMD_BYTES);
    else if (load) thr <= thr_nxt;
  end
endmodule

// File: rtl/pkt_byte_ctr.sv
module pkt_byte_ctr #(
  parameter int CMD_BYTES = pkt_thr_pkg::DEF_CMD_BYTES,
  parameter int CNT_W     = $clog2(CMD_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pkt_thr_pkg::cnt_act_e  act,
  output logic [CNT_W-1:0]       cnt,
  output logic [CNT_W-1:0]       cnt_nxt
);
  import pkt_thr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CMD_BYTES);

  always_comb begin
    unique case (act)
      CA_ZERO: cnt_nxt = '0;
      CA_INC:  cnt_nxt = (cnt == CNT_TOP) ? CNT_TOP : cnt + 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/pkt_full_flag.sv
module pkt_full_flag #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             byte_ok,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] thr,
  output logic             full
);
  logic hit;

  // A zero threshold needs one real byte before it reports full
  assign hit = byte_ok && ((thr == '0) || (cnt_nxt == thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full <= 1'b0;
    else if (restart) full <= 1'b0;
    else if (hit)     full <= 1'b1;
  end
endmodule

// File: rtl/pkt_thr_det.sv
module pkt_thr_det #(
  parameter int CMD_BYTES = pkt_thr_pkg::DEF_CMD_BYTES,
  parameter int PROG_W    = pkt_thr_pkg::DEF_PROG_W,
  localparam int CNT_W    = $clog2(CMD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drq,
  input  logic              cmd_sel,
  input  logic [PROG_W-1:0] prog_cnt,
  input  logic              wr_stb,
  input  logic              fifo_clr,
  output logic              full_flag,
  output logic [CNT_W-1:0]  byte_cnt
);
  import pkt_thr_pkg::*;

  logic             drq_rise;
  logic             byte_ok;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_nxt;
  cnt_act_e         act;

  pkt_drq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .drq      (drq),
    .drq_rise (drq_rise)
  );

  pkt_thr_latch #(
    .CMD_BYTES (CMD_BYTES),
    .PROG_W    (PROG_W),
    .CNT_W     (CNT_W)
  ) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (drq_rise),
    .cmd_sel  (cmd_sel),
    .prog_cnt (prog_cnt),
    .thr      (thr)
  );

  // Transfer start outranks clear, clear outranks a byte
  assign byte_ok = wr_stb & ~fifo_clr & ~drq_rise;

  always_comb begin
    if (drq_rise || fifo_clr) act = CA_ZERO;
    else if (wr_stb)          act = CA_INC;
    else                      act = CA_HOLD;
  end

  pkt_byte_ctr #(
    .CMD_BYTES (CMD_BYTES),
    .CNT_W     (CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .cnt     (byte_cnt),
    .cnt_nxt (cnt_nxt)
  );

  pkt_full_flag #(
    .CNT_W (CNT_W)
  ) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (drq_rise),
    .byte_ok (byte_ok),
    .cnt_nxt (cnt_nxt),
    .thr     (thr),
    .full    (full_flag)
  );
endmodule

// File: rtl/pkt_thr_det_chk.sv
module pkt_thr_det_chk #(
  parameter int CMD_BYTES = 12,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drq,
  input logic             wr_stb,
  input logic             fifo_clr,
  input logic             full_flag,
  input logic [CNT_W-1:0] byte_cnt
);
  logic drq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq_d <= 1'b0;
    else        drq_d <= drq;
  end

  // R6
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(CMD_BYTES));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !drq_d) |=> (byte_cnt == '0 && !full_flag));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (byte_cnt == '0));

  // R6
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !fifo_clr && !(drq && !drq_d) && byte_cnt < CNT_W'(CMD_BYTES))
      |=> (byte_cnt == $past(byte_cnt) + 1'b1));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && !(drq && !drq_d)) |=> full_flag);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !fifo_clr && !(drq && !drq_d)) |=> $stable(byte_cnt));
endmodule

bind pkt_thr_det pkt_thr_det_chk #(
  .CMD_BYTES (CMD_BYTES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .drq       (drq),
  .wr_stb    (wr_stb),
  .fifo_clr  (fifo_clr),
  .full_flag (full_flag),
  .byte_cnt  (byte_cnt)
);

// File: tb/pkt_thr_det_tb.sv
module pkt_thr_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drq = 1'b0;
  logic       cmd_sel = 1'b0;
  logic [3:0] prog_cnt = 4'd0;
  logic       wr_stb = 1'b0;
  logic       fifo_clr = 1'b0;
  logic       full_flag;
  logic [3:0] byte_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_thr_det u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .drq       (drq),
    .cmd_sel   (cmd_sel),
    .prog_cnt  (prog_cnt),
    .wr_stb    (wr_stb),
    .fifo_clr  (fifo_clr),
    .full_flag (full_flag),
    .byte_cnt  (byte_cnt)
  );

  // vector: [15] cmd_sel, [14:11] prog_cnt, [10:6] bytes to write,
  //         [5:2] expected count, [1] expected flag, [0] spare
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 4'd0,  5'd11, 4'd11, 1'b0, 1'b0},  // R2 one short of 12
    {1'b1, 4'd5,  5'd12, 4'd12, 1'b1, 1'b0},  // R2 exactly 12
    {1'b0, 4'd5,  5'd4,  4'd4,  1'b0, 1'b0},  // R3 one short
    {1'b0, 4'd5,  5'd5,  4'd5,  1'b1, 1'b0},  // R3 reached
    {1'b0, 4'd1,  5'd1,  4'd1,  1'b1, 1'b0},  // R3 single byte
    {1'b0, 4'd11, 5'd14, 4'd12, 1'b1, 1'b0},  // R6 saturation
    {1'b0, 4'd14, 5'd11, 4'd11, 1'b0, 1'b0},  // R3 clamp, short
    {1'b0, 4'd14, 5'd12, 4'd12, 1'b1, 1'b0},  // R3 clamp, reached
    {1'b0, 4'd0,  5'd0,  4'd0,  1'b0, 1'b0},  // R9 no byte yet
    {1'b0, 4'd0,  5'd1,  4'd1,  1'b1, 1'b0}   // R9 first byte
  };

  task automatic check(input string req, input logic [3:0] got_cnt, input logic got_flag,
                       input logic [3:0] exp_cnt, input logic exp_flag);
    checks++;
    if (got_cnt !== exp_cnt || got_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s: cnt=%0d flag=%0b expected cnt=%0d flag=%0b",
               req, got_cnt, got_flag, exp_cnt, exp_flag);
    end
  endtask

  // Raise drq with the given selection, then scramble selection (R4)
  task automatic open_xfer(input logic cs, input logic [3:0] pc);
    @(negedge clk);
    drq = 1'b0;
    @(negedge clk);
    drq = 1'b1;
    cmd_sel = cs;
    prog_cnt = pc;
    @(negedge clk);
    cmd_sel = ~cs;
    prog_cnt = pc ^ 4'h7;
  endtask

  // Hold the strobe for n edges; returns on a falling edge
  task automatic write_bytes(input int n);
    if (n > 0) begin
      wr_stb = 1'b1;
      repeat (n) @(negedge clk);
      wr_stb = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", byte_cnt, full_flag, 4'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", byte_cnt, full_flag, 4'd0, 1'b0);

    // Table walk: R2 R3 R4 R6 R9
    for (int i = 0; i < NV; i++) begin
      open_xfer(VEC[i][15], VEC[i][14:11]);
      write_bytes(int'(VEC[i][10:6]));
      check($sformatf("R2/R3/R4/R6/R9 vec%0d", i), byte_cnt, full_flag,
            VEC[i][5:2], VEC[i][1]);
    end

    // R5: drq edge and byte in the same cycle, with flag previously set
    open_xfer(1'b0, 4'd2);
    write_bytes(2);
    check("R5 setup", byte_cnt, full_flag, 4'd2, 1'b1);
    drq = 1'b0;
    @(negedge clk);
    drq = 1'b1;
    cmd_sel = 1'b0;
    prog_cnt = 4'd3;
    wr_stb = 1'b1;
    @(negedge clk);
    check("R5 collide", byte_cnt, full_flag, 4'd0, 1'b0);
    @(negedge clk);
    wr_stb = 1'b0;
    check("R5 next byte", byte_cnt, full_flag, 4'd1, 1'b0);
    write_bytes(2);
    check("R5 thr 3", byte_cnt, full_flag, 4'd3, 1'b1);

    // R7: clear with a write, flag kept (R8)
    fifo_clr = 1'b1;
    wr_stb = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    wr_stb = 1'b0;
    check("R7 clear", byte_cnt, full_flag, 4'd0, 1'b1);

    // R10: drq held high, writes count without re-latch
    write_bytes(2);
    check("R10 held", byte_cnt, full_flag, 4'd2, 1'b1);
    drq = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 fall", byte_cnt, full_flag, 4'd2, 1'b1);
    // R8: flag survives further bytes past threshold
    write_bytes(5);
    check("R8 sticky", byte_cnt, full_flag, 4'd7, 1'b1);

    // R1: reset clears flag and count
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerst", byte_cnt, full_flag, 4'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule